// File: doc/BRIEF.md
# Evicted Region Buffer with Eager Drain

When the region tag array of a large cache replaces a region entry, the resident blocks of that region still occupy the data array and must leave it. This block takes the whole victim entry in one cycle: its region tag, a per-block "resident" mask and the way number of each resident block. Data is not stored. The buffer then hands the data array one block eviction at a time through a request/acknowledge handshake. A single region replacement therefore never asks for many block evictions in the same cycle.

Victims are held in arrival order in a ring of twelve slots. Draining starts as soon as a victim arrives, so the oldest entry is always the one being served. Within an entry, resident blocks leave in ascending block-index order. A slot frees itself when its last resident block has been acknowledged. When every slot is taken, a stall output holds the cache back. A lookup port tells the cache whether a region is still pending eviction, so that a new access to that region can be caught.

Top module: `region_evict_buffer`

## Requirements
- R1: After reset, no slot is occupied (`slot_busy` is all zero), `stall` is low and `evict_valid` is low.
- R2: A victim presented with `victim_valid` high while `stall` is low, and with a nonzero resident mask, occupies one slot from the next cycle on. A victim whose resident mask is zero occupies no slot and never matches a lookup.
- R3: `stall` is high exactly when all 12 slots are occupied. A victim offered while `stall` is high is dropped: occupancy does not change and its tag does not match a lookup.
- R4: `evict_valid` is high whenever any slot is occupied. The request carries the region tag, the block index and the way of the lowest-indexed resident block of the oldest occupied entry. Bit i of the resident mask stands for block i, and the way of block i is bits [4i+3:4i] of `victim_ways`.
- R5: While `evict_valid` is high and `evict_ack` is low, the request stays valid and its tag, block index and way do not change in the next cycle.
- R6: A request acknowledged at a clock edge removes that block from its entry. The entry's slot is freed at the same edge if that was its last resident block, and its region then stops matching a lookup.
- R7: `lookup_hit` is high, in the same cycle, exactly when `lookup_tag` equals the tag of an occupied slot.
- R8: Entries are drained in the order they were accepted: every block of an older victim is requested before any block of a younger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| victim_valid | input | 1 | A region victim is offered this cycle |
| victim_tag | input | 20 | Region tag of the victim |
| victim_live | input | 16 | Resident mask, bit i for block i |
| victim_ways | input | 64 | Way of block i in bits [4i+3:4i] |
| stall | output | 1 | All slots occupied; hold the cache |
| evict_valid | output | 1 | A block eviction request is pending |
| evict_tag | output | 20 | Region tag of the requested block |
| evict_blk | output | 4 | Block index within the region |
| evict_way | output | 4 | Way holding the block |
| evict_ack | input | 1 | Data array has taken the request |
| lookup_tag | input | 20 | Region tag to probe |
| lookup_hit | output | 1 | Probed region is pending in the buffer |
| slot_busy | output | 12 | Per-slot occupancy |

## Verification
A corrupted ring pointer or resident mask shows up at the request port. The request either names the wrong region or repeats a block, and this is seen on the first acknowledge after the damage, because every request is compared against a queue of expected blocks. A slot that fails to free shows up as a stuck `slot_busy` bit and a stale `lookup_hit`. A slot that frees too early shows as a block that is never requested. Both are visible one cycle after the acknowledge that should have freed the slot. An occupancy count that drifts makes `stall` wrong. That is exposed as soon as the twelfth victim is offered.

// File: rtl/reb_pkg.sv
package reb_pkg;

    parameter int REB_TAG_W   = 20;
    parameter int REB_BLKS    = 16;
    parameter int REB_WAY_W   = 4;
    parameter int REB_ENTRIES = 12;
    parameter int REB_BLK_W   = $clog2(REB_BLKS);

    typedef logic [REB_WAY_W-1:0] way_t;

    // One buffered victim region: tag, resident mask, way per block.
    typedef struct packed {
        logic [REB_TAG_W-1:0] tag;
        logic [REB_BLKS-1:0]  live;
        way_t [REB_BLKS-1:0]  way;
    } region_t;

    // One block eviction request toward the data array.
    typedef struct packed {
        logic [REB_TAG_W-1:0] tag;
        logic [REB_BLK_W-1:0] blk;
        way_t                 way;
    } blk_req_t;

endpackage

// File: rtl/reb_first_set.sv
module reb_first_set #(
    parameter int W   = 16,
    parameter int IDX = $clog2(W)
) (
    input  logic [W-1:0]   vec,
    output logic           found,
    output logic [IDX-1:0] idx
);
    // Lowest set bit wins: scan from the top so the lowest index is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX'(i);
        end
    end
endmodule

// File: rtl/reb_tag_match.sv
module reb_tag_match #(
    parameter int N     = 12,
    parameter int TAG_W = 20
) (
    input  logic [N-1:0]       valid,
    input  logic [N*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]   key,
    output logic               hit
);
    logic [N-1:0] per_slot;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign per_slot[i] = valid[i] && (tags[i*TAG_W +: TAG_W] == key);
    end

    assign hit = |per_slot;
endmodule

// File: rtl/region_evict_buffer.sv
module region_evict_buffer
    import reb_pkg::*;
#(
    parameter int ENTRIES = REB_ENTRIES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      victim_valid,
    input  logic [REB_TAG_W-1:0]      victim_tag,
    input  logic [REB_BLKS-1:0]       victim_live,
    input  logic [REB_BLKS*REB_WAY_W-1:0] victim_ways,
    output logic                      stall,
    output logic                      evict_valid,
    output logic [REB_TAG_W-1:0]      evict_tag,
    output logic [REB_BLK_W-1:0]      evict_blk,
    output logic [REB_WAY_W-1:0]      evict_way,
    input  logic                      evict_ack,
    input  logic [REB_TAG_W-1:0]      lookup_tag,
    output logic                      lookup_hit,
    output logic [ENTRIES-1:0]        slot_busy
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    region_t              slots [ENTRIES];
    logic [ENTRIES-1:0]   occ;
    logic [PTR_W-1:0]     head, tail;

    region_t              head_ent;
    region_t              incoming;
    blk_req_t             req;
    logic                 head_found;
    logic [REB_BLK_W-1:0] head_blk;
    logic [REB_BLKS-1:0]  head_left;
    logic                 accept, retire, last_blk;
    logic [ENTRIES*REB_TAG_W-1:0] tag_flat;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_ent = slots[head];

    assign incoming.tag  = victim_tag;
    assign incoming.live = victim_live;
    assign incoming.way  = victim_ways;

    reb_first_set #(.W(REB_BLKS), .IDX(REB_BLK_W)) u_pick (
        .vec   (head_ent.live),
        .found (head_found),
        .idx   (head_blk)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tags
        assign tag_flat[i*REB_TAG_W +: REB_TAG_W] = slots[i].tag;
    end

    reb_tag_match #(.N(ENTRIES), .TAG_W(REB_TAG_W)) u_match (
        .valid (occ),
        .tags  (tag_flat),
        .key   (lookup_tag),
        .hit   (lookup_hit)
    );

    assign req.tag = head_ent.tag;
    assign req.blk = head_blk;
    assign req.way = head_ent.way[head_blk];

    assign stall       = &occ;
    assign evict_valid = occ[head] && head_found;
    assign evict_tag   = req.tag;
    assign evict_blk   = req.blk;
    assign evict_way   = req.way;
    assign slot_busy   = occ;

    assign accept    = victim_valid && !stall && (|victim_live);
    assign retire    = evict_valid && evict_ack;
    assign head_left = head_ent.live & ~(REB_BLKS'(1) << head_blk);
    assign last_blk  = (head_left == '0);

    // Tail == head only when empty (no retire) or full (no accept),
    // so the two writes below never land on the same slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            occ  <= '0;
            head <= '0;
            tail <= '0;
        end else begin
            if (accept) begin
                slots[tail] <= incoming;
                occ[tail]   <= 1'b1;
                tail        <= bump(tail);
            end
            if (retire) begin
                slots[head].live <= head_left;
                if (last_blk) begin
                    occ[head] <= 1'b0;
                    head      <= bump(head);
                end
            end
        end
    end
endmodule

// File: rtl/reb_checker.sv
module reb_checker
    import reb_pkg::*;
#(
    parameter int ENTRIES = REB_ENTRIES
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 victim_valid,
    input logic                 stall,
    input logic                 evict_valid,
    input logic [REB_TAG_W-1:0] evict_tag,
    input logic [REB_BLK_W-1:0] evict_blk,
    input logic [REB_WAY_W-1:0] evict_way,
    input logic                 evict_ack,
    input logic                 lookup_hit,
    input logic [ENTRIES-1:0]   slot_busy
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_busy == '0 && !evict_valid && !stall));

    assert_stall_full_R3: assert property (@(posedge clk) disable iff (rst)
        stall == ($countones(slot_busy) == ENTRIES));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (stall && !(evict_valid && evict_ack)) |=>
            ($countones(slot_busy) == ENTRIES));

    assert_req_when_busy_R4: assert property (@(posedge clk) disable iff (rst)
        evict_valid == (slot_busy != '0));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && !evict_ack) |=>
            (evict_valid && $stable(evict_tag) && $stable(evict_blk) && $stable(evict_way)));

    assert_free_one_R6: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ack && !victim_valid) |=>
            ($countones(slot_busy) + 1 >= $countones($past(slot_busy))));

    assert_hit_needs_slot_R7: assert property (@(posedge clk) disable iff (rst)
        lookup_hit |-> (slot_busy != '0));
endmodule

bind region_evict_buffer reb_checker #(.ENTRIES(ENTRIES)) u_reb_checker (
    .clk          (clk),
    .rst          (rst),
    .victim_valid (victim_valid),
    .stall        (stall),
    .evict_valid  (evict_valid),
    .evict_tag    (evict_tag),
    .evict_blk    (evict_blk),
    .evict_way    (evict_way),
    .evict_ack    (evict_ack),
    .lookup_hit   (lookup_hit),
    .slot_busy    (slot_busy)
);

// File: tb/region_evict_buffer_test.sv
module region_evict_buffer_test;
    import reb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic victim_valid = 1'b0;
    logic [REB_TAG_W-1:0] victim_tag = '0;
    logic [REB_BLKS-1:0] victim_live = '0;
    logic [REB_BLKS*REB_WAY_W-1:0] victim_ways = '0;
    logic stall, evict_valid, lookup_hit;
    logic [REB_TAG_W-1:0] evict_tag;
    logic [REB_BLK_W-1:0] evict_blk;
    logic [REB_WAY_W-1:0] evict_way;
    logic evict_ack = 1'b0;
    logic [REB_TAG_W-1:0] lookup_tag = '0;
    logic [NSLOT-1:0] slot_busy;

    int checks = 0;
    int fails  = 0;
    int credits = 0;
    bit finished = 0;
    blk_req_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    region_evict_buffer #(.ENTRIES(NSLOT)) uut (
        .clk(clk), .rst(rst),
        .victim_valid(victim_valid), .victim_tag(victim_tag),
        .victim_live(victim_live), .victim_ways(victim_ways),
        .stall(stall), .evict_valid(evict_valid), .evict_tag(evict_tag),
        .evict_blk(evict_blk), .evict_way(evict_way), .evict_ack(evict_ack),
        .lookup_tag(lookup_tag), .lookup_hit(lookup_hit), .slot_busy(slot_busy)
    );

    function automatic logic [REB_WAY_W-1:0] way_of(input logic [REB_TAG_W-1:0] t, input int b);
        return REB_WAY_W'((t + b * 3) & 15);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: offers one victim for one cycle; expected blocks go to the scoreboard.
    task automatic offer(input logic [REB_TAG_W-1:0] t, input logic [REB_BLKS-1:0] m);
        @(negedge clk);
        victim_valid = 1'b1;
        victim_tag   = t;
        victim_live  = m;
        for (int b = 0; b < REB_BLKS; b++)
            victim_ways[b*REB_WAY_W +: REB_WAY_W] = way_of(t, b);
        if (!stall && m != '0) begin
            for (int b = 0; b < REB_BLKS; b++) begin
                if (m[b]) expq.push_back('{tag: t, blk: REB_BLK_W'(b), way: way_of(t, b)});
            end
        end
        @(negedge clk);
        victim_valid = 1'b0;
    endtask

    task automatic probe(input logic [REB_TAG_W-1:0] t, input bit exp, input string req);
        lookup_tag = t;
        #1;
        check(lookup_hit == exp, req, lookup_hit, exp);
    endtask

    // Monitor: compares every acknowledged request with the scoreboard head (R4, R8).
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && evict_valid && credits > 0) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4 unexpected request", evict_tag, 0);
                end else begin
                    blk_req_t e;
                    e = expq.pop_front();
                    check(evict_tag == e.tag, "R8 tag order", evict_tag, e.tag);
                    check(evict_blk == e.blk && evict_way == e.way, "R4 block/way",
                          {evict_blk, evict_way}, {e.blk, e.way});
                end
                credits--;
                evict_ack = 1'b1;
            end else begin
                evict_ack = 1'b0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(slot_busy == '0 && !stall && !evict_valid, "R1 reset state",
              {stall, evict_valid, slot_busy}, 0);

        // R5: request held while not acknowledged
        offer(20'h00100, 16'b1010);
        offer(20'h00200, 16'b0001);
        #1;
        check($countones(slot_busy) == 2, "R2 two slots busy", $countones(slot_busy), 2);
        check(evict_valid && evict_tag == 20'h00100 && evict_blk == 1 && evict_way == way_of(20'h00100, 1),
              "R4 first request", {evict_tag, evict_blk}, {20'h00100, 4'd1});
        repeat (3) @(negedge clk);
        #1;
        check(evict_valid && evict_tag == 20'h00100 && evict_blk == 1, "R5 held without ack",
              {evict_tag, evict_blk}, {20'h00100, 4'd1});
        probe(20'h00100, 1'b1, "R7 pending region hit");
        probe(20'h00300, 1'b0, "R7 absent region miss");

        // R6: one ack leaves entry with one block; second ack frees it
        @(posedge clk); credits = 1;
        @(negedge clk); @(negedge clk); #1;
        check($countones(slot_busy) == 2, "R6 entry kept while blocks remain", $countones(slot_busy), 2);
        @(posedge clk); credits = 1;
        @(negedge clk); @(negedge clk); #1;
        check($countones(slot_busy) == 1, "R6 entry freed after last block", $countones(slot_busy), 1);
        probe(20'h00100, 1'b0, "R6 freed region no longer hits");
        check(evict_tag == 20'h00200 && evict_blk == 0, "R8 next region served",
              evict_tag, 20'h00200);

        // R2: zero mask victim is not stored
        offer(20'h00400, 16'h0000);
        #1;
        check($countones(slot_busy) == 1, "R2 empty victim dropped", $countones(slot_busy), 1);
        probe(20'h00400, 1'b0, "R2 empty victim no hit");

        // R3: fill all slots, then offer one more
        for (int k = 0; k < NSLOT - 1; k++) offer(20'h01000 + k, 16'h8001 | (16'h1 << k));
        #1;
        check(stall == 1'b1, "R3 stall when full", stall, 1);
        check($countones(slot_busy) == NSLOT, "R3 all slots busy", $countones(slot_busy), NSLOT);
        offer(20'h0BEEF, 16'hFFFF);
        #1;
        check($countones(slot_busy) == NSLOT, "R3 victim ignored when full", $countones(slot_busy), NSLOT);
        probe(20'h0BEEF, 1'b0, "R3 ignored victim no hit");
        probe(20'h01005, 1'b1, "R7 young region hit");

        // Drain everything freely
        @(posedge clk); credits = 1000000;
        offer(20'h02000, 16'hF00F);
        for (int k = 0; k < 2000 && (expq.size() != 0 || evict_valid); k++) @(negedge clk);
        #1;
        check(expq.size() == 0, "R8 every expected block requested", expq.size(), 0);
        check(slot_busy == '0 && !stall && !evict_valid, "R6 buffer empty after drain",
              {stall, evict_valid, slot_busy}, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule